// File: doc/BRIEF.md
# Multi-Rate Serial TDM Stream Port

This block is a bank of serial time-division streams that share one frame pulse and one clock. Each stream has its own transmit rate and its own receive rate. Each rate is picked from four speeds by a 4-bit code. On the receive side the block samples each incoming serial line in the middle of every bit. It gathers eight bits into a channel byte and reports the byte with its channel index. The stream index is the lane position in the packed vectors.

On the transmit side the block names the channel whose slot starts next and takes a byte and a "slot in use" flag for it. It then shifts the byte out most significant bit first at that stream's rate. A pad enable tells the pad when the line is driven. The lower half of the bank also has active-high controls for external tristate buffers.

Either half of the bank can be switched to bidirectional operation. In that mode the dedicated inputs of that half are forced low. Received data is then taken from the pad side of the stream's own output pin. The clock runs at twice the fastest bit rate, so the fastest stream sends one bit every two clocks.

Top module: `tdm_stream_port`

## Requirements
- R1: A frame counter of 2^FRAME_LOG clocks (4096 by default) wraps freely. When `fp_i` is high at a clock edge, the count is 0 in the following cycle.
- R2: Rate code 0, 1, 2 or 3 makes each bit last 16, 8, 4 or 2 clocks. A frame then holds 32, 64, 128 or 256 channels. No stream runs faster than half the clock.
- R3: Transmit bits go out most significant bit first. Bit 7 of channel 0 is on `sto_o` in the cycle right after the edge that sampled `fp_i`.
- R4: `tx_take_o` is high in the last cycle before a slot starts, with the slot's channel on `tx_chan_o`. `tx_byte_i` and `tx_vld_i` are captured at that edge. While `fp_i` is high, every enabled stream shows take with channel 0.
- R5: Receive sampling happens half a bit period into each bit. One cycle after the sample of the last bit (bit 0) of a channel, `rx_vld_o` pulses for one cycle with the byte and channel of that slot. At code 3, channel 0 is reported 16 cycles after the frame edge. At code 0 it is reported 121 cycles after.
- R6: With each output looped to its input and the streams at different rates, every received byte equals the byte supplied for that stream and channel.
- R7: Rate codes 4 to 15 disable a direction. A disabled transmitter keeps `sto_oe_o` low and raises no take. A disabled receiver raises no `rx_vld_o`.
- R8: If `tx_vld_i` is low when a slot's byte is captured, `sto_oe_o` stays low for that whole slot. Otherwise it is high for the slot.
- R9: `hiz_o[k]` exists only for streams in the lower half of the bank. A value of 1 means the external buffer must be high impedance, which is exactly when stream k is not driving.
- R10: `bidir_i[0]` puts the lower half into bidirectional mode and `bidir_i[1]` does the same for the upper half; the two are independent. In a bidirectional half, `sti_i` is forced low and data is received from `sio_i`. In a normal half, `sio_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twice the fastest stream rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| fp_i | input | 1 | Frame pulse, restarts the frame count |
| bidir_i | input | 2 | Bidirectional enable: bit 0 lower half, bit 1 upper half |
| rx_rate_i | input | 4*NUM_STREAMS | Receive rate code per stream |
| tx_rate_i | input | 4*NUM_STREAMS | Transmit rate code per stream |
| sti_i | input | NUM_STREAMS | Dedicated serial inputs |
| sio_i | input | NUM_STREAMS | Pad-side value of each output pin, used as input in bidirectional mode |
| tx_byte_i | input | 8*NUM_STREAMS | Byte for the channel named on tx_chan_o |
| tx_vld_i | input | NUM_STREAMS | Slot carries data; low leaves the slot undriven |
| tx_take_o | output | NUM_STREAMS | Byte capture strobe per stream |
| tx_chan_o | output | (FRAME_LOG-4)*NUM_STREAMS | Channel index of the slot being captured |
| sto_o | output | NUM_STREAMS | Serial output data |
| sto_oe_o | output | NUM_STREAMS | Pad drive enable per stream |
| hiz_o | output | NUM_STREAMS/2 | External buffer high-impedance control, lower half only |
| rx_vld_o | output | NUM_STREAMS | Received byte strobe |
| rx_byte_o | output | 8*NUM_STREAMS | Received byte |
| rx_chan_o | output | (FRAME_LOG-4)*NUM_STREAMS | Channel index of the received byte |

## Verification
The hardest case to provoke is bidirectional mode taking data from the wrong source. With plain loopback, both candidate pins carry the same bits, so a mistake stays hidden. The stimulus therefore loops each output back only to the pin that should be read and holds the other pin at constant one. Every supplied byte has its top bit clear, so a wrong source shows up as a mismatch on every channel. A frame pulse arriving in the middle of a running frame is also driven directly. The first bits and the first reported channels after it are then timed against the counted clock positions.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
    localparam int RATE_W   = 4;
    localparam int BYTE_W   = 8;
    localparam int TOP_CODE = 3;
    localparam int SLOT_LOG = 3;   // eight bits per channel
    localparam int POS_W    = 16;  // working width for frame position arithmetic

    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [POS_W-1:0]  pos_t;

    // A code selects a rate only in the range 0..TOP_CODE.
    function automatic logic rate_ok(rate_t r);
        return r <= rate_t'(TOP_CODE);
    endfunction

    // log2 of clocks per bit: code 0 -> 4 (16 clocks) ... code 3 -> 1 (2 clocks)
    function automatic logic [2:0] bit_shift(rate_t r);
        return 3'(5'd4 - {1'b0, r});
    endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
    parameter int FRAME_LOG = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fp_i,
    output logic [FRAME_LOG-1:0] cnt_q_o,
    output logic [FRAME_LOG-1:0] cnt_d_o
);
    typedef struct packed {
        logic [FRAME_LOG-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fp_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;

    p_fp_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fp_i |=> (cnt_q_o == '0));

    p_free_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_i |=> (cnt_q_o == $past(cnt_q_o) + 1'b1));
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
    import tdm_pkg::*;
#(
    parameter int FRAME_LOG = 12,
    parameter int CHAN_W    = FRAME_LOG - 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  rate_t                rate_i,
    input  logic [FRAME_LOG-1:0] cnt_q_i,
    input  logic [FRAME_LOG-1:0] cnt_d_i,
    input  byte_t                byte_i,
    input  logic                 vld_i,
    output logic                 take_o,
    output logic [CHAN_W-1:0]    chan_o,
    output logic                 ser_o,
    output logic                 oe_o
);
    typedef struct packed {
        byte_t data;
        logic  vld;
    } txs_t;

    txs_t st_d, st_q;

    pos_t       pos_now, pos_next, slot_mask;
    logic [2:0] sh, bit_idx;
    logic       en;

    assign en        = rate_ok(rate_i);
    assign sh        = bit_shift(rate_i);
    assign pos_now   = pos_t'(cnt_q_i);
    assign pos_next  = pos_t'(cnt_d_i);
    assign slot_mask = (pos_t'(1) << (sh + 3'd3)) - pos_t'(1);
    assign bit_idx   = 3'(pos_now >> sh);

    assign take_o = en && ((pos_next & slot_mask) == '0);
    assign chan_o = CHAN_W'(pos_next >> (sh + 3'd3));

    always_comb begin
        st_d = st_q;
        if (take_o) begin
            st_d.data = byte_i;
            st_d.vld  = vld_i;
        end
        if (!en) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_o = en ? st_q.data[3'd7 - bit_idx] : 1'b0;
    assign oe_o  = en && st_q.vld;

    p_take_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (!$stable(rate_i) || ser_o == $past(byte_i[7])));

    p_idle_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && !vld_i) |=> !oe_o);
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
    import tdm_pkg::*;
#(
    parameter int FRAME_LOG = 12,
    parameter int CHAN_W    = FRAME_LOG - 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  rate_t                rate_i,
    input  logic [FRAME_LOG-1:0] cnt_q_i,
    input  logic                 din_i,
    output logic                 vld_o,
    output byte_t                byte_o,
    output logic [CHAN_W-1:0]    chan_o
);
    typedef struct packed {
        byte_t             shreg;
        byte_t             data;
        logic [CHAN_W-1:0] chan;
        logic              vld;
    } rxs_t;

    rxs_t st_d, st_q;

    pos_t       pos_now, in_bit_mask, mid;
    logic [2:0] sh, bit_idx;
    logic       en, at_mid;

    assign en          = rate_ok(rate_i);
    assign sh          = bit_shift(rate_i);
    assign pos_now     = pos_t'(cnt_q_i);
    assign in_bit_mask = (pos_t'(1) << sh) - pos_t'(1);
    assign mid         = pos_t'(1) << (sh - 3'd1);
    assign bit_idx     = 3'(pos_now >> sh);
    assign at_mid      = en && ((pos_now & in_bit_mask) == mid);

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (at_mid) begin
            st_d.shreg = {st_q.shreg[6:0], din_i};
            if (bit_idx == 3'd7) begin
                st_d.data = {st_q.shreg[6:0], din_i};
                st_d.chan = CHAN_W'(pos_now >> (sh + 3'd3));
                st_d.vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o  = st_q.vld;
    assign byte_o = st_q.data;
    assign chan_o = st_q.chan;

    p_rx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_ok(rate_i) |=> !vld_o);

    p_rx_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);
endmodule

// File: rtl/tdm_stream_port.sv
module tdm_stream_port
    import tdm_pkg::*;
#(
    parameter int NUM_STREAMS = 4,
    parameter int FRAME_LOG   = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              fp_i,
    input  logic [1:0]                        bidir_i,
    input  logic [NUM_STREAMS*RATE_W-1:0]     rx_rate_i,
    input  logic [NUM_STREAMS*RATE_W-1:0]     tx_rate_i,
    input  logic [NUM_STREAMS-1:0]            sti_i,
    input  logic [NUM_STREAMS-1:0]            sio_i,
    input  logic [NUM_STREAMS*BYTE_W-1:0]     tx_byte_i,
    input  logic [NUM_STREAMS-1:0]            tx_vld_i,
    output logic [NUM_STREAMS-1:0]            tx_take_o,
    output logic [NUM_STREAMS*(FRAME_LOG-4)-1:0] tx_chan_o,
    output logic [NUM_STREAMS-1:0]            sto_o,
    output logic [NUM_STREAMS-1:0]            sto_oe_o,
    output logic [NUM_STREAMS/2-1:0]          hiz_o,
    output logic [NUM_STREAMS-1:0]            rx_vld_o,
    output logic [NUM_STREAMS*BYTE_W-1:0]     rx_byte_o,
    output logic [NUM_STREAMS*(FRAME_LOG-4)-1:0] rx_chan_o
);
    localparam int CHAN_W = FRAME_LOG - 4;
    localparam int HALF   = NUM_STREAMS / 2;

    logic [FRAME_LOG-1:0] cnt_q, cnt_d;

    tdm_frame_timer #(.FRAME_LOG(FRAME_LOG)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .fp_i    (fp_i),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_d)
    );

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
        localparam int GRP = (s < HALF) ? 0 : 1;
        logic bidir_on, sti_forced, din;

        assign bidir_on   = bidir_i[GRP];
        assign sti_forced = sti_i[s] & ~bidir_on;
        assign din        = bidir_on ? sio_i[s] : sti_forced;

        tdm_tx_lane #(.FRAME_LOG(FRAME_LOG), .CHAN_W(CHAN_W)) u_tx (
            .clk     (clk),
            .rst_n   (rst_n),
            .rate_i  (tx_rate_i[s*RATE_W +: RATE_W]),
            .cnt_q_i (cnt_q),
            .cnt_d_i (cnt_d),
            .byte_i  (tx_byte_i[s*BYTE_W +: BYTE_W]),
            .vld_i   (tx_vld_i[s]),
            .take_o  (tx_take_o[s]),
            .chan_o  (tx_chan_o[s*CHAN_W +: CHAN_W]),
            .ser_o   (sto_o[s]),
            .oe_o    (sto_oe_o[s])
        );

        tdm_rx_lane #(.FRAME_LOG(FRAME_LOG), .CHAN_W(CHAN_W)) u_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .rate_i  (rx_rate_i[s*RATE_W +: RATE_W]),
            .cnt_q_i (cnt_q),
            .din_i   (din),
            .vld_o   (rx_vld_o[s]),
            .byte_o  (rx_byte_o[s*BYTE_W +: BYTE_W]),
            .chan_o  (rx_chan_o[s*CHAN_W +: CHAN_W])
        );
    end

    for (genvar h = 0; h < HALF; h++) begin : g_hiz
        assign hiz_o[h] = ~sto_oe_o[h];
    end
endmodule

// File: tb/tdm_stream_port_tb.sv
module tdm_stream_port_tb;
    localparam int NS    = 4;
    localparam int FL    = 12;
    localparam int CW    = FL - 4;
    localparam int HALF  = NS / 2;
    localparam int FRAME = 1 << FL;

    // {bidir[1:0], code s3, code s2, code s1, code s0}; tx and rx share codes
    localparam logic [17:0] VEC [5] = '{
        {2'b00, 4'd3,  4'd2, 4'd1, 4'd0},
        {2'b01, 4'd0,  4'd1, 4'd2, 4'd3},
        {2'b10, 4'd2,  4'd0, 4'd3, 4'd1},
        {2'b11, 4'd1,  4'd3, 4'd0, 4'd2},
        {2'b00, 4'd15, 4'd3, 4'd9, 4'd0}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst_n, fp_i;
    logic [1:0]          bidir;
    logic [NS*4-1:0]     rates;
    logic [NS-1:0]       sti, sio, tx_vld, tx_take, sto, sto_oe, rx_vld;
    logic [NS*8-1:0]     tx_byte, rx_byte;
    logic [NS*CW-1:0]    tx_chan, rx_chan;
    logic [HALF-1:0]     hiz;

    tdm_stream_port #(.NUM_STREAMS(NS), .FRAME_LOG(FL)) u_dut (
        .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .bidir_i(bidir),
        .rx_rate_i(rates), .tx_rate_i(rates), .sti_i(sti), .sio_i(sio),
        .tx_byte_i(tx_byte), .tx_vld_i(tx_vld), .tx_take_o(tx_take),
        .tx_chan_o(tx_chan), .sto_o(sto), .sto_oe_o(sto_oe), .hiz_o(hiz),
        .rx_vld_o(rx_vld), .rx_byte_o(rx_byte), .rx_chan_o(rx_chan)
    );

    int checks = 0, fails = 0;
    logic done = 1'b0;
    logic chk_en = 1'b0;
    logic [FL-1:0] bcnt;
    int rxcount [NS];

    function automatic logic [7:0] pat(int s, int c);
        return 8'((s * 37 + c * 5 + 11) & 127);
    endfunction

    function automatic logic idle_ch(int c);
        return (c % 7) == 3;
    endfunction

    function automatic logic in_bidir(int s);
        return (s < HALF) ? bidir[0] : bidir[1];
    endfunction

    task automatic chk(logic ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // byte source and loopback wiring: the pin that must be ignored sits at 1
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            tx_byte[s*8 +: 8] = pat(s, int'(tx_chan[s*CW +: CW]));
            tx_vld[s]         = !idle_ch(int'(tx_chan[s*CW +: CW]));
            sti[s]            = in_bidir(s) ? 1'b1 : sto[s];
            sio[s]            = in_bidir(s) ? sto[s] : 1'b1;
        end
    end

    // frame position model from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bcnt <= '1;
        else        bcnt <= fp_i ? '0 : bcnt + 1'b1;
    end

    always @(negedge clk) begin
        if (chk_en) begin
            for (int s = 0; s < NS; s++) begin
                automatic int  r    = int'(rates[s*4 +: 4]);
                automatic logic en  = (r <= 3);
                automatic int  sh   = 4 - r;
                automatic int  cur  = int'(bcnt);
                automatic int  prv  = (cur + FRAME - 1) % FRAME;
                automatic int  ch   = int'(rx_chan[s*CW +: CW]);
                automatic logic exp_oe;
                if (rx_vld[s]) begin
                    rxcount[s]++;
                    if (!en) begin
                        chk(1'b0, "R7 rx strobe on disabled stream", 1, 0);
                    end else begin
                        chk(ch == (prv >> (sh + 3)), "R1 R5 rx channel", ch, prv >> (sh + 3));
                        if (in_bidir(s))
                            chk(rx_byte[s*8 +: 8] == pat(s, ch), "R10 bidir rx byte",
                                int'(rx_byte[s*8 +: 8]), int'(pat(s, ch)));
                        else
                            chk(rx_byte[s*8 +: 8] == pat(s, ch), "R6 loopback rx byte",
                                int'(rx_byte[s*8 +: 8]), int'(pat(s, ch)));
                    end
                end
                exp_oe = en && !idle_ch(cur >> (sh + 3));
                chk(sto_oe[s] == exp_oe, "R7 R8 drive enable", int'(sto_oe[s]), int'(exp_oe));
                if (s < HALF)
                    chk(hiz[s] == !exp_oe, "R9 hiz control", int'(hiz[s]), int'(!exp_oe));
            end
        end
    end

    task automatic wait_pos(int n);
        while (int'(bcnt) != n) @(negedge clk);
    endtask

    task automatic pulse_fp();
        @(negedge clk);
        fp_i = 1'b1;
        @(negedge clk);
        fp_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        fp_i  = 1'b0;
        bidir = 2'b00;
        rates = VEC[0][15:0];
        repeat (3) @(negedge clk);
        // reset state
        chk(rx_vld == '0, "R5 reset rx strobe", int'(rx_vld), 0);
        chk(sto_oe == '0, "R8 reset drive enable", int'(sto_oe), 0);
        chk(hiz == '1, "R9 reset hiz", int'(hiz), 3);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);

        // mid-frame pulse: capture, first bits and first reports
        fp_i = 1'b1;
        #1;
        chk(tx_take == 4'hF, "R4 take at frame pulse", int'(tx_take), 15);
        chk(tx_chan == '0, "R4 channel at frame pulse", int'(tx_chan), 0);
        @(negedge clk);
        fp_i = 1'b0;
        chk(bcnt == 0, "R1 restart", int'(bcnt), 0);
        chk(sto[3] == pat(3, 0)[7], "R3 first bit code 3", int'(sto[3]), int'(pat(3, 0)[7]));
        chk(sto[0] == pat(0, 0)[7], "R3 first bit code 0", int'(sto[0]), int'(pat(0, 0)[7]));
        wait_pos(2);
        chk(sto[3] == pat(3, 0)[6], "R2 two-clock bit", int'(sto[3]), int'(pat(3, 0)[6]));
        wait_pos(15);
        chk(sto[0] == pat(0, 0)[7], "R2 sixteen-clock bit held", int'(sto[0]), int'(pat(0, 0)[7]));
        chk(rx_vld[3] == 1'b0, "R5 no early report", int'(rx_vld[3]), 0);
        wait_pos(16);
        chk(sto[0] == pat(0, 0)[6], "R2 sixteen-clock bit ends", int'(sto[0]), int'(pat(0, 0)[6]));
        chk(rx_vld[3] == 1'b1, "R5 code 3 report at 16", int'(rx_vld[3]), 1);
        chk(rx_chan[3*CW +: CW] == 0, "R5 code 3 channel", int'(rx_chan[3*CW +: CW]), 0);
        chk(rx_byte[3*8 +: 8] == pat(3, 0), "R5 code 3 byte", int'(rx_byte[3*8 +: 8]), int'(pat(3, 0)));
        wait_pos(121);
        chk(rx_vld[0] == 1'b1, "R5 code 0 report at 121", int'(rx_vld[0]), 1);
        chk(rx_byte[0 +: 8] == pat(0, 0), "R5 code 0 byte", int'(rx_byte[0 +: 8]), int'(pat(0, 0)));

        // table of rate mixes and bidirectional groupings
        for (int v = 0; v < 5; v++) begin
            @(negedge clk);
            rates = VEC[v][15:0];
            bidir = VEC[v][17:16];
            repeat (20) @(negedge clk);
            pulse_fp();
            @(posedge clk);
            for (int s = 0; s < NS; s++) rxcount[s] = 0;
            chk_en = 1'b1;
            repeat (FRAME) @(posedge clk);
            chk_en = 1'b0;
            for (int s = 0; s < NS; s++) begin
                automatic int r = int'(rates[s*4 +: 4]);
                automatic int n = (r <= 3) ? (32 << r) : 0;
                chk(rxcount[s] == n, "R2 R7 channels per frame", rxcount[s], n);
            end
        end
        finish_run();
    end
endmodule